// File: doc/BRIEF.md
# External Static Memory Write-Cycle Timer

This block performs one write access to an external asynchronous static memory at a time. An internal requester presents an address, a write word and a strobe timing set, and raises a request. The block samples the request together with all of its inputs, drives the address and data onto the memory bus, and shapes two active-low strobes: a write strobe and a chip select. It signals completion with a one-cycle acknowledge.

Each strobe has its own setup count and pulse count, measured in clock cycles from the first cycle of the access. The whole access has its own length count. This lets the write strobe and the chip select fall and rise at different points of one shared access. A strobe window that would run past the end of the access is cut short, so both strobes are high again when the access ends. Between accesses both strobes stay high and the data drivers are off.

Top module: `smc_write_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_we_n and mem_cs_n are 1, and mem_doe and ack are 0.
- R2: mem_addr and mem_dout take the req_addr and req_data values sampled at the clock edge that accepts a request. They hold those values for the whole access, even if the request inputs change.
- R3: Number the access cycles k = 0 .. L-1, where cycle 0 follows the accepting edge. mem_we_n is 0 exactly in the cycles with ws_setup <= k < ws_setup + max(ws_pulse,1), limited to k < L.
- R4: mem_cs_n follows the same rule with cs_setup and cs_pulse, independently of the write strobe values.
- R5: The access length L equals cyc_len, and a cyc_len of 0 is taken as 1. ack is 1 only in cycle L-1, for one cycle.
- R6: No strobe is low in cycle L or later. A strobe whose setup is at least L never goes low in that access.
- R7: A request is accepted only while idle. A request held high during an access is ignored, and at least one idle cycle follows every access, with both strobes high and mem_doe at 0.
- R8: mem_doe is 1 in exactly the cycles 0 .. L-1 of an access.
- R9: A pulse count of 0 gives a strobe low for one cycle, if its setup is below L.
- R10: ws_setup, ws_pulse, cs_setup, cs_pulse and cyc_len are sampled at the accepting edge. Changes to them during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Write request, sampled while idle |
| req_addr | input | ADDR_W (24) | Write address |
| req_data | input | DATA_W (16) | Write word |
| ws_setup | input | 6 | Write strobe setup count |
| ws_pulse | input | 6 | Write strobe pulse count (0 acts as 1) |
| cs_setup | input | 6 | Chip select setup count |
| cs_pulse | input | 6 | Chip select pulse count (0 acts as 1) |
| cyc_len | input | 6 | Access length in cycles (0 acts as 1) |
| ack | output | 1 | One-cycle completion pulse in the last access cycle |
| mem_addr | output | ADDR_W (24) | Memory address bus |
| mem_dout | output | DATA_W (16) | Memory data bus output value |
| mem_doe | output | 1 | Data bus output enable |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |

## Verification
Some properties are checked on every cycle: the acknowledge is a single-cycle pulse that is always followed by an idle cycle, no strobe is low outside an access, the address does not move during an access, and the internal cycle counter stays below the latched length. Only the scoreboard scenarios can show the exact cycle in which each strobe falls and rises for a given setup, pulse and length. The same holds for the zero-pulse and zero-length substitutions, the clipping of windows that overrun the access, and the fact that request and timing inputs changed in mid-access are ignored.

// File: rtl/smc_wr_pkg.sv
package smc_wr_pkg;

    localparam int CNT_W = 6;

    typedef logic [CNT_W-1:0] tcnt_t;

    typedef struct packed {
        tcnt_t setup;
        tcnt_t pulse;
    } strobe_cfg_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } seq_st_e;

    // A count of zero is promoted to one (pulse widths and access length).
    function automatic tcnt_t at_least_one(tcnt_t v);
        return (v == '0) ? tcnt_t'(1) : v;
    endfunction

    // True when access cycle k lies inside the strobe window, clipped to len.
    function automatic logic in_window(tcnt_t k, strobe_cfg_t c, tcnt_t len);
        logic [CNT_W:0] stop;
        logic [CNT_W:0] lim;
        stop = {1'b0, c.setup} + {1'b0, at_least_one(c.pulse)};
        lim  = {1'b0, len};
        if (stop > lim) stop = lim;
        return ({1'b0, k} >= {1'b0, c.setup}) && ({1'b0, k} < stop);
    endfunction

endpackage

// File: rtl/wr_seq_ctrl.sv
module wr_seq_ctrl
    import smc_wr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  tcnt_t cyc_len,
    output logic  accept,
    output logic  nxt_active,
    output tcnt_t nxt_cnt,
    output tcnt_t nxt_len,
    output logic  ack
);

    seq_st_e st;
    tcnt_t   cnt;
    tcnt_t   len_q;
    logic    last;

    always_comb begin
        accept  = (st == ST_IDLE) && req;
        nxt_len = accept ? at_least_one(cyc_len) : len_q;
        last    = (st == ST_ACCESS) && (cnt == tcnt_t'(len_q - 1'b1));
        if (st == ST_IDLE) begin
            nxt_active = req;
            nxt_cnt    = '0;
        end else begin
            nxt_active = !last;
            nxt_cnt    = last ? '0 : tcnt_t'(cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            len_q <= tcnt_t'(1);
            ack   <= 1'b0;
        end else begin
            st  <= nxt_active ? ST_ACCESS : ST_IDLE;
            cnt <= nxt_cnt;
            if (accept) len_q <= nxt_len;
            ack <= nxt_active && (nxt_cnt == tcnt_t'(nxt_len - 1'b1));
        end
    end

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACCESS) |-> (cnt < len_q));                            // R5
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACCESS) |-> !accept);                                  // R7

endmodule

// File: rtl/wr_strobe_gen.sv
module wr_strobe_gen
    import smc_wr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  strobe_cfg_t cfg_in,
    input  logic        nxt_active,
    input  tcnt_t       nxt_cnt,
    input  tcnt_t       nxt_len,
    output logic        strobe_n
);

    strobe_cfg_t cfg_q;
    strobe_cfg_t cfg_use;

    always_comb cfg_use = accept ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            strobe_n <= 1'b1;
        end else begin
            if (accept) cfg_q <= cfg_in;
            strobe_n <= !(nxt_active && in_window(nxt_cnt, cfg_use, nxt_len));
        end
    end

    AST_STROBE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !$past(nxt_active) |-> strobe_n);                                // R6

endmodule

// File: rtl/wr_data_path.sv
module wr_data_path #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              nxt_active,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_dout <= '0;
            mem_doe  <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                mem_dout <= req_data;
            end
            mem_doe <= nxt_active;
        end
    end

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_doe && $past(mem_doe)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R2

endmodule

// File: rtl/smc_write_timer.sv
module smc_write_timer
    import smc_wr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CNT_W-1:0]  ws_setup,
    input  logic [CNT_W-1:0]  ws_pulse,
    input  logic [CNT_W-1:0]  cs_setup,
    input  logic [CNT_W-1:0]  cs_pulse,
    input  logic [CNT_W-1:0]  cyc_len,
    output logic              ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    output logic              mem_we_n,
    output logic              mem_cs_n
);

    localparam int N_STROBE = 2;

    logic        accept;
    logic        nxt_active;
    tcnt_t       nxt_cnt;
    tcnt_t       nxt_len;
    strobe_cfg_t cfg_in [N_STROBE];
    logic        strb_n [N_STROBE];

    always_comb begin
        cfg_in[0] = '{setup: ws_setup, pulse: ws_pulse};
        cfg_in[1] = '{setup: cs_setup, pulse: cs_pulse};
    end

    wr_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cyc_len    (cyc_len),
        .accept     (accept),
        .nxt_active (nxt_active),
        .nxt_cnt    (nxt_cnt),
        .nxt_len    (nxt_len),
        .ack        (ack)
    );

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        wr_strobe_gen u_strobe (
            .clk        (clk),
            .rst        (rst),
            .accept     (accept),
            .cfg_in     (cfg_in[g]),
            .nxt_active (nxt_active),
            .nxt_cnt    (nxt_cnt),
            .nxt_len    (nxt_len),
            .strobe_n   (strb_n[g])
        );
    end

    assign mem_we_n = strb_n[0];
    assign mem_cs_n = strb_n[1];

    wr_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .nxt_active (nxt_active),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .mem_doe    (mem_doe)
    );

    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_doe |-> (mem_we_n && mem_cs_n));                            // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);                                                   // R5
    AST_ACK_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !mem_doe);                                               // R8
    AST_ACK_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
        ack |-> mem_doe);                                                // R8

endmodule

// File: tb/tb_smc_write_timer.sv
module tb_smc_write_timer;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    typedef struct {
        logic              we_n;
        logic              cs_n;
        logic              ack;
        logic              doe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [5:0]        ws_setup = '0, ws_pulse = '0, cs_setup = '0, cs_pulse = '0, cyc_len = '0;
    logic              ack, mem_doe, mem_we_n, mem_cs_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dout;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    smc_write_timer dut (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
        .ws_setup(ws_setup), .ws_pulse(ws_pulse), .cs_setup(cs_setup), .cs_pulse(cs_pulse),
        .cyc_len(cyc_len), .ack(ack), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n)
    );

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected strobe level from the requirement formulas (R3, R4, R6, R9).
    function automatic logic exp_low(int k, int s, int p, int len);
        int stop;
        stop = s + ((p == 0) ? 1 : p);
        if (stop > len) stop = len;
        return (k >= s) && (k < stop);
    endfunction

    // Monitor: pops one expected item per cycle, sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(mem_we_n === e.we_n, {e.tag, " we_n"}, mem_we_n, e.we_n);
            check(mem_cs_n === e.cs_n, {e.tag, " cs_n"}, mem_cs_n, e.cs_n);
            check(ack === e.ack, {e.tag, " R5 ack"}, ack, e.ack);
            check(mem_doe === e.doe, {e.tag, " R8 doe"}, mem_doe, e.doe);
            if (e.doe) begin
                check(mem_addr === e.addr, {e.tag, " R2 addr"}, mem_addr, e.addr);
                check(mem_dout === e.data, {e.tag, " R2 data"}, mem_dout, e.data);
            end
        end
    end

    // Driver: issues one write and pushes the expected per-cycle items.
    task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                            int wss, int wsp, int css, int csp, int cl,
                            bit hold_req, string tag);
        int len;
        len = (cl == 0) ? 1 : cl;
        @(negedge clk);
        req_addr = a; req_data = d;
        ws_setup = 6'(wss); ws_pulse = 6'(wsp);
        cs_setup = 6'(css); cs_pulse = 6'(csp);
        cyc_len  = 6'(cl);
        req = 1'b1;
        @(posedge clk);
        #1;
        for (int k = 0; k < len; k++) begin
            exp_t e;
            e.we_n = !exp_low(k, wss, wsp, len);
            e.cs_n = !exp_low(k, css, csp, len);
            e.ack  = (k == len - 1);
            e.doe  = 1'b1;
            e.addr = a;
            e.data = d;
            e.tag  = tag;
            q.push_back(e);
        end
        begin
            exp_t idle;
            idle.we_n = 1'b1; idle.cs_n = 1'b1; idle.ack = 1'b0; idle.doe = 1'b0;
            idle.addr = a; idle.data = d; idle.tag = {tag, " R7 idle"};
            q.push_back(idle);
        end
        if (hold_req) begin
            // R2 R10 R7: scramble every request input and keep req high.
            req_addr = ~a; req_data = ~d;
            ws_setup = 6'd0; ws_pulse = 6'd63; cs_setup = 6'd0; cs_pulse = 6'd63;
            cyc_len = 6'd63;
        end else begin
            req = 1'b0;
        end
        for (int k = 0; k < len; k++) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        check(mem_we_n === 1'b1, "R1 we_n in reset", mem_we_n, 1);
        check(mem_cs_n === 1'b1, "R1 cs_n in reset", mem_cs_n, 1);
        check(mem_doe === 1'b0, "R1 doe in reset", mem_doe, 0);
        check(ack === 1'b0, "R1 ack in reset", ack, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_we_n === 1'b1 && mem_cs_n === 1'b1 && mem_doe === 1'b0 && ack === 1'b0,
              "R1 after reset", {mem_we_n, mem_cs_n, mem_doe, ack}, 4'b1100);

        do_write(24'h12_3456, 16'hA5C3, 2, 3, 1, 5, 8, 1'b0, "R3 R4 basic");
        do_write(24'hFE_DCBA, 16'h0F0F, 0, 0, 3, 0, 5, 1'b0, "R9 zero pulse");
        do_write(24'h00_0001, 16'h8001, 4, 10, 6, 2, 7, 1'b0, "R6 clip");
        do_write(24'h55_AA55, 16'h1234, 9, 2, 0, 1, 4, 1'b0, "R6 late setup");
        do_write(24'h80_0000, 16'hFFFF, 0, 3, 0, 0, 0, 1'b0, "R5 zero length");
        do_write(24'h3C_3C3C, 16'h6666, 1, 2, 0, 4, 6, 1'b1, "R2 R10 held inputs");
        do_write(24'hAB_CDEF, 16'h7777, 10, 20, 5, 40, 63, 1'b0, "R5 long access");
        do_write(24'h11_1111, 16'h2222, 0, 1, 0, 2, 2, 1'b0, "R7 back to back a");
        do_write(24'h22_2222, 16'h4444, 1, 1, 0, 3, 3, 1'b0, "R7 back to back b");

        repeat (2) @(negedge clk);
        check(q.size() == 0, "R8 scoreboard drained", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule